// File: doc/BRIEF.md
# Burst Address Generator for Serial Pseudo-SRAM

This block produces the byte address sequence that a pseudo-SRAM burst walks through. A controller loads a start address with a one-cycle strobe. After that, each one-cycle advance strobe steps the presented address once. The data path and the serial pins live elsewhere. This block only decides which byte comes next.

Two burst styles are supported, and a persistent mode bit selects between them. In linear style the address counts through the whole 23-bit array. It runs straight across 1 KB page edges and rolls from the last byte back to zero. In wrap style only the five low bits count, so the burst circles inside its aligned 32-byte window. A toggle strobe flips the mode bit, and reset puts it back to linear. Whenever a linear step carries the low ten bits from 1023 to 0, a one-cycle flag tells the controller that the burst has entered a new page, so it can run at the reduced clock rate that page crossing needs.

The control core is a two-state machine. `ST_IDLE` means no burst is loaded, and it is the state after reset. `ST_BURST` means an address is being presented. The machine has three transitions:
- `ST_IDLE` to `ST_BURST` on a load.
- `ST_BURST` to `ST_BURST` on a load, which restarts the burst.
- `ST_BURST` to `ST_BURST` on an advance, which steps the address.

With no strobe the machine stays in its state. Reset is the only way back to `ST_IDLE`.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, `addr_valid_o`=0, `addr_o`=0, `wrap_mode_o`=0 (linear) and `page_cross_o`=0. Reset also returns a design that is in wrap mode to linear.
- R2: Each cycle with `mode_toggle_i`=1 inverts `wrap_mode_o` at the next clock edge (1 = 32-byte wrap, 0 = linear). Without a toggle the mode holds.
- R3: A cycle with `load_i`=1 makes `addr_o` equal `start_addr_i` and `addr_valid_o`=1 after the next edge. A load takes priority over an advance in the same cycle.
- R4: In linear mode an advance while `addr_valid_o`=1 makes `addr_o` equal to the previous address plus one after the next edge, continuing across 1 KB page boundaries (…1023, 1024, 1025…).
- R5: In wrap mode an advance increments only bits [4:0] modulo 32 and holds bits [22:5] (…31, 0, 1… within the window).
- R6: `page_cross_o` is 1 for exactly the cycle in which `addr_o` shows the result of a linear advance that took bits [9:0] from 1023 to 0. It is 0 after a load, after a wrap-mode advance and in all other cycles.
- R7: An advance while `addr_valid_o`=0 is ignored. With no load and no advance, `addr_o` holds its value.
- R8: In linear mode, advancing from address 0x7FFFFF gives address 0 and raises `page_cross_o`.
- R9: When a toggle and a load fall in the same cycle, the advances of the loaded burst follow the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_toggle_i | input | 1 | One-cycle strobe that flips the linear/wrap mode |
| load_i | input | 1 | One-cycle strobe that starts a burst at start_addr_i |
| start_addr_i | input | 23 | Burst start byte address |
| advance_i | input | 1 | One-cycle strobe that steps to the next address |
| addr_o | output | 23 | Current burst byte address |
| addr_valid_o | output | 1 | A burst is loaded and addr_o is meaningful |
| wrap_mode_o | output | 1 | 1 = 32-byte wrap mode, 0 = linear mode |
| page_cross_o | output | 1 | addr_o just entered a new 1 KB page through a linear step |

## Verification
The bench builds the block with its default parameters: a 23-bit address, a 10-bit page offset and a 5-bit wrap window. These widths keep a full page walk short. A burst that starts at byte 4 reaches the 1023-to-1024 crossing after about a thousand advances. Loading a start near 0x7FFFFF brings the top-of-array rollover within a few steps. The bench also runs wrap bursts in the highest window of the array, to show that the upper bits stay fixed there. It also places a toggle and a load in the same cycle, in both directions of the mode change.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Burst addressing style held by the mode register.
    typedef enum logic {
        MODE_LINEAR = 1'b0,
        MODE_WRAP   = 1'b1
    } burst_mode_e;

    // Control states of the generator.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        toggle_i,
    output burst_mode_e mode_o
);

    burst_mode_e mode_q;
    burst_mode_e mode_d;

    // Each toggle strobe inverts the stored style.
    always_comb begin
        mode_d = mode_q;
        if (toggle_i) begin
            unique case (mode_q)
                MODE_LINEAR: mode_d = MODE_WRAP;
                MODE_WRAP:   mode_d = MODE_LINEAR;
                default:     mode_d = MODE_LINEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_LINEAR;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int PAGE_W = 10,
    parameter int WRAP_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  burst_mode_e       mode_i,
    output logic [ADDR_W-1:0] next_o,
    output logic              cross_o
);

    localparam int HIGH_W = ADDR_W - WRAP_W;

    logic [ADDR_W-1:0] lin_next;
    logic [ADDR_W-1:0] wrap_next;
    logic              page_top;

    // Linear step: full-width increment, rolls from all-ones to zero.
    assign lin_next = addr_i + ADDR_W'(1);

    // Last byte of the current page.
    assign page_top = &addr_i[PAGE_W-1:0];

    // Wrap step: only the window offset counts.
    generate
        if (WRAP_W >= ADDR_W) begin : g_wrap_full
            assign wrap_next = lin_next;
        end else begin : g_wrap_part
            logic [WRAP_W-1:0] low_next;
            logic [HIGH_W-1:0] high_keep;
            assign low_next  = addr_i[WRAP_W-1:0] + WRAP_W'(1);
            assign high_keep = addr_i[ADDR_W-1:WRAP_W];
            assign wrap_next = {high_keep, low_next};
        end
    endgenerate

    always_comb begin
        next_o  = lin_next;
        cross_o = 1'b0;
        unique case (mode_i)
            MODE_LINEAR: begin
                next_o  = lin_next;
                cross_o = page_top;
            end
            MODE_WRAP: begin
                next_o  = wrap_next;
                cross_o = 1'b0;
            end
            default: begin
                next_o  = lin_next;
                cross_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int PAGE_W = 10,
    parameter int WRAP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_toggle_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_valid_o,
    output logic              wrap_mode_o,
    output logic              page_cross_o
);

    burst_state_e      state_q;
    burst_state_e      state_d;
    burst_mode_e       mode;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;
    logic              cross_q;
    logic              cross_d;
    logic [ADDR_W-1:0] step_addr;
    logic              step_cross;

    burst_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .toggle_i (mode_toggle_i),
        .mode_o   (mode)
    );

    burst_next_addr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .WRAP_W (WRAP_W)
    ) u_next (
        .addr_i  (addr_q),
        .mode_i  (mode),
        .next_o  (step_addr),
        .cross_o (step_cross)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            cross_q <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            cross_q <= cross_d;
        end
    end

    // Transitions and datapath selection. A load wins over an advance.
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        cross_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load_i) begin
                    state_d = ST_BURST;
                    addr_d  = start_addr_i;
                end
            end
            ST_BURST: begin
                if (load_i) begin
                    addr_d = start_addr_i;
                end else if (advance_i) begin
                    addr_d  = step_addr;
                    cross_d = step_cross;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        addr_o       = addr_q;
        page_cross_o = cross_q;
        wrap_mode_o  = (mode == MODE_WRAP);
        addr_valid_o = (state_q == ST_BURST);
    end

endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
    parameter int ADDR_W = 23,
    parameter int PAGE_W = 10,
    parameter int WRAP_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_toggle_i,
    input logic              load_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              advance_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              addr_valid_o,
    input logic              wrap_mode_o,
    input logic              page_cross_o
);

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_toggle_i |=> (wrap_mode_o != $past(wrap_mode_o))); // R2

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_toggle_i |=> $stable(wrap_mode_o)); // R2

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_valid_o && addr_o == $past(start_addr_i) && !page_cross_o)); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && advance_i && !load_i && !wrap_mode_o)
        |=> (addr_o == $past(addr_o) + ADDR_W'(1))); // R4

    AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && advance_i && !load_i && wrap_mode_o)
        |=> (addr_o[WRAP_W-1:0] == $past(addr_o[WRAP_W-1:0]) + WRAP_W'(1))); // R5

    AST_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && advance_i && !load_i && wrap_mode_o)
        |=> (addr_o[ADDR_W-1:WRAP_W] == $past(addr_o[ADDR_W-1:WRAP_W]))); // R5

    AST_CROSS_AT_PAGE_START: assert property (@(posedge clk) disable iff (!rst_n)
        page_cross_o |-> (addr_o[PAGE_W-1:0] == '0 && !wrap_mode_o)); // R6

    AST_NO_CROSS_IN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_mode_o && !load_i) |=> !page_cross_o); // R6

    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid_o && !load_i) |=> (!addr_valid_o && $stable(addr_o))); // R7

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !advance_i) |=> ($stable(addr_o) && !page_cross_o)); // R7

    AST_TOP_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && advance_i && !load_i && !wrap_mode_o && (&addr_o))
        |=> (addr_o == '0 && page_cross_o)); // R8

endmodule

bind burst_addr_gen burst_addr_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .WRAP_W (WRAP_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_toggle_i (mode_toggle_i),
    .load_i        (load_i),
    .start_addr_i  (start_addr_i),
    .advance_i     (advance_i),
    .addr_o        (addr_o),
    .addr_valid_o  (addr_valid_o),
    .wrap_mode_o   (wrap_mode_o),
    .page_cross_o  (page_cross_o)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;

    localparam int AW = 23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_toggle_i = 1'b0;
    logic          load_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic          advance_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic          addr_valid_o;
    logic          wrap_mode_o;
    logic          page_cross_o;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    int m_addr  = 0;
    bit m_valid = 0;
    bit m_wrap  = 0;
    bit m_cross = 0;

    always #2 clk = ~clk;

    burst_addr_gen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_toggle_i (mode_toggle_i),
        .load_i        (load_i),
        .start_addr_i  (start_addr_i),
        .advance_i     (advance_i),
        .addr_o        (addr_o),
        .addr_valid_o  (addr_valid_o),
        .wrap_mode_o   (wrap_mode_o),
        .page_cross_o  (page_cross_o)
    );

    task automatic compare(input string tag);
        checks++;
        if (int'(addr_o) != m_addr || addr_valid_o != m_valid ||
            wrap_mode_o != m_wrap || page_cross_o != m_cross) begin
            errors++;
            $display("FAIL %s: actual addr=%h valid=%0b wrap=%0b cross=%0b expected addr=%h valid=%0b wrap=%0b cross=%0b",
                     tag, addr_o, addr_valid_o, wrap_mode_o, page_cross_o,
                     m_addr, m_valid, m_wrap, m_cross);
        end
    endtask

    // One clock: drive at a falling edge, predict, compare at the next falling edge.
    task automatic cyc(input bit tog, input bit ld, input int sa, input bit adv, input string tag);
        mode_toggle_i = tog;
        load_i        = ld;
        start_addr_i  = AW'(sa);
        advance_i     = adv;
        m_cross = 0;
        if (ld) begin
            m_addr  = sa;
            m_valid = 1;
        end else if (adv && m_valid) begin
            if (m_wrap) begin
                m_addr = (m_addr & ~31) | ((m_addr + 1) & 31);
            end else begin
                m_cross = ((m_addr & 1023) == 1023);
                m_addr  = (m_addr + 1) & ((1 << AW) - 1);
            end
        end
        if (tog) m_wrap = !m_wrap;
        @(negedge clk);
        mode_toggle_i = 0;
        load_i        = 0;
        advance_i     = 0;
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        m_addr = 0; m_valid = 0; m_wrap = 0; m_cross = 0;
        @(negedge clk);
        compare(tag);
        rst_n = 1'b1;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL all: watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        do_reset("R1");

        // R7: advance with no burst loaded is ignored
        cyc(0, 0, 0, 1, "R7");
        cyc(0, 0, 0, 1, "R7");

        // R3, R4, R6: linear burst from 4 across the first page boundary
        cyc(0, 1, 4, 0, "R3");
        for (int i = 0; i < 1025; i++) cyc(0, 0, 0, 1, "R4_R6");
        // R7: hold without strobes
        cyc(0, 0, 0, 0, "R7");
        cyc(0, 0, 0, 0, "R7");

        // R6: load onto a page start does not flag
        cyc(0, 1, 2048, 0, "R6");
        cyc(0, 0, 0, 1, "R6");

        // R2, R5: switch to wrap, burst from 4 around the window
        cyc(1, 0, 0, 0, "R2");
        cyc(0, 1, 4, 0, "R3");
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 1, "R5");

        // R5, R6: wrap window ending at a page top never flags
        cyc(0, 1, 32'h3FC, 0, "R5");
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, "R5_R6");

        // R9: toggle with load, back to linear for the new burst
        cyc(1, 1, 32'h1FE, 0, "R9");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, "R9");
        // R9: toggle with load, into wrap for the new burst
        cyc(1, 1, 32'h11E, 0, "R9");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, "R9");

        // R3: load wins over a simultaneous advance
        cyc(0, 1, 32'h2345, 1, "R3");
        cyc(0, 1, 32'h4000, 1, "R3");

        // R5: wrap in the top window of the array
        cyc(0, 1, 32'h7FFFFC, 0, "R5");
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, "R5");

        // R8: linear rollover at the top of the array
        cyc(1, 1, 32'h7FFFFE, 0, "R8");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, "R8");

        // R2: toggles mid-burst change following steps
        cyc(1, 0, 0, 1, "R2");
        cyc(0, 0, 0, 1, "R2");
        cyc(1, 0, 0, 0, "R2");

        // R1: reset from wrap mode returns to linear
        cyc(1, 1, 32'h55, 0, "R1");
        cyc(0, 0, 0, 1, "R1");
        do_reset("R1");
        cyc(0, 0, 0, 1, "R7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule